// File: doc/BRIEF.md
# Adaptive Zero-Current Switch Timing Controller

This block drives the two power switches of a boost converter that runs in discontinuous conduction mode. An external phase input is high for the charging interval of each switching period. While it is high the low-side gate is on. When it falls, the block waits one dead tick, closes the high-side switch for a conduction window taken from a table of sixteen geometrically spaced widths, and then opens it again. A fixed number of reference ticks after the opening, it takes a single sample of a one-bit comparator that watches the switch node.

The sample drives a bang-bang loop on a 4-bit width code. A high reading means the node was still above the comparator threshold, so the switch opened while current still flowed. The code steps up to lengthen the next window. A low reading means the switch opened after the current had reversed, so the code steps down. In steady state the code toggles between two neighbouring entries that straddle the zero-current instant. A status output reports this toggling once it has lasted for a programmable number of updates. All widths and delays are counted in ticks of the fast reference clock.

Top module: `zcs_timing_ctrl`

## Requirements
- R1: After reset the width code is 8 (mid-scale), both gate outputs and the sample strobe are low, and the lock flag is low for any nonzero lock length. The gates stay off until the phase input first goes high.
- R2: The low-side gate is high from the tick after the phase input is seen high until the tick after it is seen low. The high-side gate rises exactly one tick after the low-side gate falls.
- R3: The high-side gate stays high for exactly W[code] consecutive ticks. W[0] = BASE_TICKS and W[k+1] = W[k] + max(1, floor(W[k]*GROW_NUM/GROW_DEN)). With the defaults (20, 1, 8) this gives 20, 22, 24, 27, 30, 33, 37, 41, 46, 51, 57, 64, 72, 81, 91, 102, so the steps grow with the code.
- R4: The sample strobe is high for exactly one tick. That tick is the MEAS_TICKS-th tick after the high-side gate falls, counting the first tick with the gate low as 1. The strobe occurs once per switching cycle.
- R5: On the strobe tick the code rises by one if the comparator input is 1 and falls by one if it is 0. The new value is visible on the next tick. The code changes at no other time.
- R6: The code saturates: it stays at 15 on a high reading and at 0 on a low reading, and never wraps.
- R7: The two gates are never high in the same tick.
- R8: An update counts as alternating when the new code equals the code held before the previous update and differs from the current code. The number of consecutive alternating updates is kept, saturating at 255, and is cleared by any update that does not alternate. The lock flag is high while that count is at least the lock-length input. Both the history code and the count start from 8 and 0 at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; one tick is the time unit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_i | input | 1 | High during the charging interval of each period |
| node_hi_i | input | 1 | Comparator reading of the switch node (1 = above half output voltage) |
| lock_len_i | input | 8 | Number of consecutive alternating updates that sets the lock flag |
| ls_gate_o | output | 1 | Low-side switch gate |
| hs_gate_o | output | 1 | High-side switch gate |
| sample_o | output | 1 | One-tick strobe at which the comparator is taken |
| code_o | output | 4 | Current width code |
| locked_o | output | 1 | Code has alternated between two neighbours long enough |

## Verification
A corrupted width code shows up in the very next switching cycle as a high-side pulse whose length does not match the table entry. The bench measures every pulse in ticks, so such an error is caught within one period. A wrong measurement counter moves the strobe relative to the falling gate edge, and a wrong update rule or a missing saturation moves the code away from the value the plant model predicts. Both are checked on the tick after each strobe. A fault in the alternation history is slower to appear: the lock flag only diverges after as many alternating updates as the lock length asks for. The bench therefore drives a converged plant for several periods and also drives long monotonic ramps that must clear the flag.

// File: rtl/zcs_pkg.sv
package zcs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_CHARGE = 3'd1,
    ST_DEAD   = 3'd2,
    ST_HS     = 3'd3,
    ST_MEAS   = 3'd4
  } zcs_state_e;

  // Entry k of the geometric width series, in reference ticks.
  function automatic int unsigned geo_width(input int unsigned base,
                                            input int unsigned gnum,
                                            input int unsigned gden,
                                            input int unsigned idx);
    int unsigned w;
    int unsigned step;
    w = base;
    for (int unsigned i = 0; i < idx; i++) begin
      step = (w * gnum) / gden;
      if (step == 0) step = 1;
      w = w + step;
    end
    return w;
  endfunction

endpackage

// File: rtl/zcs_width_rom.sv
module zcs_width_rom #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned BASE_TICKS = 20,
  parameter int unsigned GROW_NUM   = 1,
  parameter int unsigned GROW_DEN   = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  width_o
);
  localparam int unsigned ENTRIES = 1 << CODE_W;

  logic [CNT_W-1:0] tab [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    localparam int unsigned WK = zcs_pkg::geo_width(BASE_TICKS, GROW_NUM, GROW_DEN, k);
    assign tab[k] = CNT_W'(WK);
  end

  assign width_o = tab[code_i];

endmodule

// File: rtl/zcs_seq_fsm.sv
module zcs_seq_fsm #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned MEAS_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             ls_gate_o,
  output logic             hs_gate_o,
  output logic             sample_o
);
  import zcs_pkg::*;

  localparam logic [CNT_W-1:0] MEAS_LOAD = CNT_W'(MEAS_TICKS - 1);

  zcs_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (phase_i) state_d = ST_CHARGE;
      end
      ST_CHARGE: begin
        if (!phase_i) state_d = ST_DEAD;
      end
      ST_DEAD: begin
        state_d = ST_HS;
        cnt_d   = width_i - CNT_W'(1);
        cnt_en  = 1'b1;
      end
      ST_HS: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_MEAS;
          cnt_d   = MEAS_LOAD;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_MEAS: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_WAIT;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ls_gate_o = (state_q == ST_CHARGE);
  assign hs_gate_o = (state_q == ST_HS);
  assign sample_o  = (state_q == ST_MEAS) && (cnt_q == '0);

endmodule

// File: rtl/zcs_code_loop.sv
module zcs_code_loop #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              node_hi_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));
  localparam logic [LOCK_W-1:0] RUN_MAX  = {LOCK_W{1'b1}};

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] hist_q;
  logic [LOCK_W-1:0] run_q, run_d;
  logic              alt;

  always_comb begin
    code_d = code_q;
    if (node_hi_i) begin
      if (code_q != CODE_MAX) code_d = code_q + CODE_W'(1);
    end else begin
      if (code_q != '0) code_d = code_q - CODE_W'(1);
    end
    alt   = (code_d == hist_q) && (code_d != code_q);
    run_d = alt ? ((run_q == RUN_MAX) ? run_q : run_q + LOCK_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_MID;
      hist_q <= CODE_MID;
      run_q  <= '0;
    end else if (sample_i) begin
      code_q <= code_d;
      hist_q <= code_q;
      run_q  <= run_d;
    end
  end

  assign code_o   = code_q;
  assign locked_o = (run_q >= lock_len_i);

endmodule

// File: rtl/zcs_timing_ctrl.sv
module zcs_timing_ctrl #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned LOCK_W     = 8,
  parameter int unsigned BASE_TICKS = 20,
  parameter int unsigned GROW_NUM   = 1,
  parameter int unsigned GROW_DEN   = 8,
  parameter int unsigned MEAS_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_i,
  input  logic              node_hi_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic              ls_gate_o,
  output logic              hs_gate_o,
  output logic              sample_o,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o
);
  logic [CNT_W-1:0] width;
  logic             strobe;

  zcs_width_rom #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS),
    .GROW_NUM(GROW_NUM), .GROW_DEN(GROW_DEN)
  ) u_rom (
    .code_i (code_o),
    .width_o(width)
  );

  zcs_seq_fsm #(
    .CNT_W(CNT_W), .MEAS_TICKS(MEAS_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase_i),
    .width_i  (width),
    .ls_gate_o(ls_gate_o),
    .hs_gate_o(hs_gate_o),
    .sample_o (strobe)
  );

  zcs_code_loop #(
    .CODE_W(CODE_W), .LOCK_W(LOCK_W)
  ) u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (strobe),
    .node_hi_i (node_hi_i),
    .lock_len_i(lock_len_i),
    .code_o    (code_o),
    .locked_o  (locked_o)
  );

  assign sample_o = strobe;

endmodule

// File: rtl/zcs_timing_ctrl_chk.sv
module zcs_timing_ctrl_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phase_i,
  input logic              node_hi_i,
  input logic              ls_gate_o,
  input logic              hs_gate_o,
  input logic              sample_o,
  input logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  p_gate_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_gate_o && hs_gate_o));

  p_dead_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> $past(ls_gate_o) == 1'b0);

  p_ls_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> $past(phase_i));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  p_strobe_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> !hs_gate_o);

  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |=> $stable(code_o));

  p_code_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && node_hi_i && code_o != CODE_MAX) |=> code_o == $past(code_o) + CODE_W'(1));

  p_code_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !node_hi_i && code_o != '0) |=> code_o == $past(code_o) - CODE_W'(1));

  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && node_hi_i && code_o == CODE_MAX) |=> code_o == CODE_MAX);

  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !node_hi_i && code_o == '0) |=> code_o == '0);

endmodule

bind zcs_timing_ctrl zcs_timing_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase_i  (phase_i),
  .node_hi_i(node_hi_i),
  .ls_gate_o(ls_gate_o),
  .hs_gate_o(hs_gate_o),
  .sample_o (sample_o),
  .code_o   (code_o)
);

// File: tb/zcs_timing_ctrl_test.sv
`timescale 1ns/1ps
module zcs_timing_ctrl_test;
  localparam int MEAS   = 4;
  localparam int BASE   = 20;
  localparam int GNUM   = 1;
  localparam int GDEN   = 8;
  localparam int CHG    = 40;
  localparam int PERIOD = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic       node_hi = 1'b0;
  logic [7:0] lock_len = 8'd3;
  logic       ls, hs, smp, locked;
  logic [3:0] code;

  always #5 clk = ~clk;

  zcs_timing_ctrl #(.BASE_TICKS(BASE), .GROW_NUM(GNUM), .GROW_DEN(GDEN),
                    .MEAS_TICKS(MEAS)) uut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .node_hi_i(node_hi),
    .lock_len_i(lock_len), .ls_gate_o(ls), .hs_gate_o(hs), .sample_o(smp),
    .code_o(code), .locked_o(locked));

  typedef struct { int width; int code; bit lk; } exp_t;
  exp_t q[$];
  exp_t cur;

  int n_chk = 0, n_fail = 0;
  int wtab[16];
  int mc = 8, mhist = 8, mrun = 0;
  int target = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: predict the cycle outcome from the requirements, then run it.
  task automatic run_cycle(input int tgt);
    exp_t e;
    int nc;
    bit alt;
    target = tgt;
    e.width = wtab[mc];
    if (e.width < tgt) nc = (mc == 15) ? 15 : mc + 1;
    else               nc = (mc == 0)  ? 0  : mc - 1;
    alt = (nc == mhist) && (nc != mc);
    mhist = mc;
    mrun = alt ? ((mrun == 255) ? 255 : mrun + 1) : 0;
    mc = nc;
    e.code = nc;
    e.lk = (mrun >= int'(lock_len));
    q.push_back(e);
    @(negedge clk); phase = 1'b1;
    repeat (CHG) @(negedge clk);
    phase = 1'b0;
    repeat (PERIOD - CHG) @(negedge clk);
  endtask

  // Monitor plus plant model.
  bit hs_p = 0, ls_p = 0, ph_p = 0, pend = 0;
  int hs_len = 0, since = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(ls && hs), "R7 gates overlap", int'(ls & hs), 0);
      if (ls && !ls_p) check(ph_p, "R2 ls rise needs phase", int'(ph_p), 1);
      if (hs && !hs_p) check(!ls && !ls_p && ph_p == 0, "R2 dead tick", int'(ls_p), 0);
      if (hs) hs_len++;
      if (hs_p && !hs) begin
        node_hi = (hs_len < target);
        if (q.size() == 0) begin
          check(1'b0, "R3 unexpected pulse", hs_len, 0);
          cur.width = 0; cur.code = code; cur.lk = locked;
        end else begin
          cur = q.pop_front();
          check(hs_len == cur.width, "R3 pulse width", hs_len, cur.width);
        end
        hs_len = 0;
        since = 1;
      end else if (since != 0) begin
        since++;
      end
      if (smp) begin
        check(since == MEAS, "R4 strobe position", since, MEAS);
        since = 0;
        pend = 1;
      end else if (pend) begin
        pend = 0;
        check(int'(code) == cur.code, "R5 R6 code update", code, cur.code);
        check(locked == cur.lk, "R8 lock flag", locked, cur.lk);
      end
      hs_p = hs; ls_p = ls; ph_p = phase;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      int st;
      if (k == 0) wtab[k] = BASE;
      else begin
        st = wtab[k-1] * GNUM / GDEN;
        if (st < 1) st = 1;
        wtab[k] = wtab[k-1] + st;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state and idle gates before first charge
    check(code == 4'd8, "R1 reset code", code, 8);
    check(!ls && !hs, "R1 gates off", int'({ls, hs}), 0);
    check(!smp, "R1 strobe low", smp, 0);
    check(!locked, "R1 lock low", locked, 0);
    // Convergence around an ideal width of 60 ticks: lock expected (R8)
    for (int i = 0; i < 10; i++) run_cycle(60);
    check(locked, "R8 locked after alternation", locked, 1);
    // Ideal width between entries 4 and 5 after a long descent (R5, R8 clear)
    for (int i = 0; i < 12; i++) run_cycle(31);
    // Top saturation (R6)
    for (int i = 0; i < 14; i++) run_cycle(1000);
    check(code == 4'd15, "R6 top saturation", code, 15);
    // Bottom saturation (R6)
    for (int i = 0; i < 18; i++) run_cycle(0);
    check(code == 4'd0, "R6 bottom saturation", code, 0);
    // Longer lock length with a converged plant (R8)
    lock_len = 8'd6;
    for (int i = 0; i < 12; i++) run_cycle(25);
    check(q.size() == 0, "R4 one pulse per cycle", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule